// File: doc/BRIEF.md
# Zero-Page Single-Bit Instruction Sequencer

This block runs one single-bit instruction of an 8-bit processor against a byte-wide synchronous memory port. A one-cycle start pulse, together with a program counter, launches the sequence. The block then drives every access itself. It fetches the opcode and the zero-page operand, reads the zero-page byte, and then takes one of two paths. For a bit clear/set instruction it rewrites the byte. For a test-and-branch instruction it fetches the branch offset and works out where execution continues.

The opcode itself carries everything the block needs. The high bit gives the polarity, the next three bits name the bit, and the low nibble gives the instruction group. Both groups take five bus cycles. A done strobe returns the next program counter, and another flag marks opcodes that belong to neither group. No processor flag is produced or changed.

Top module: `bitop_seq`

## Requirements
- R1: During and after reset, with no start, `done`, `illegal`, `mem_req` and `mem_we` are all low.
- R2: Opcode bits [3:0] pick the group: 0x7 is bit clear/set and 0xF is test-and-branch. Bits [6:4] pick the bit, where 0 is the least significant bit of the byte and 7 the most significant. Bit 7 is the polarity.
- R3: A bit clear/set instruction has five cycles T1..T5. T1 reads the PC and T2 reads PC+1. T3 reads the zero-page byte and T4 reads it again with `mem_we` low. T5 writes the modified byte to the same address with `mem_we` high.
- R4: A test-and-branch instruction has five cycles T1..T5. T1 reads the PC and T2 reads PC+1. T3 reads the zero-page byte and T4 reads PC+2. T5 has no bus access (`mem_req` low).
- R5: The branch is taken when the selected bit equals opcode bit 7. A taken branch gives PC+3 plus the sign-extended offset, modulo 2^16. A branch not taken gives PC+3.
- R6: After a bit clear/set instruction, the next PC is PC+2.
- R7: `done` is high for exactly one cycle, the cycle after T5, and the next PC is valid with it. A start pulse is accepted only when the block is idle. Start pulses during a sequence have no effect.
- R8: Any other opcode gives a sequence of T1 and T2 only. `done` and `illegal` are then high together in the next cycle, with the next PC equal to PC+1, and nothing is written.
- R9: The read data in a cycle is the byte addressed in the cycle before (one-cycle latency). The zero-page address is on bus bits [7:0] and bits [15:8] are zero.
- R10: Opcode bit 7 = 0 clears the selected bit and opcode bit 7 = 1 sets it. The other seven bits keep the value that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_pc | input | 16 | Address of the opcode |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Opcode outside both groups, valid with done |
| next_pc | output | 16 | Program counter to continue from, valid with done |

## Verification
The bench runs all 32 opcodes. Each test-and-branch opcode runs once with its bit set and once with it clear. A design that inverts the polarity, or that picks the bit in the wrong order, therefore takes the wrong exit. Offsets 0x7F, 0x80 and 0xFF, forward and backward page crossings, and a wrap past 0xFFFF expose an offset that is zero-extended or a carry that is lost. The written byte is compared in full, which catches a modification that disturbs neighbouring bits or that uses the dummy read's data. Start pulses in mid-sequence and illegal opcodes check that a busy sequence cannot be restarted and that an unknown code ends early with PC+1.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_T1, ST_T2, ST_T3, ST_T4, ST_T5, ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      GRP_MODIFY, GRP_BRANCH, GRP_NONE
   } op_group_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opcode,
   output op_group_t         group,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              polarity
);
   always_comb begin
      unique case (opcode[3:0])
         4'h7:    group = GRP_MODIFY;
         4'hF:    group = GRP_BRANCH;
         default: group = GRP_NONE;
      endcase
   end

   assign bit_idx  = opcode[IDX_W+3:4];
   assign polarity = opcode[DATA_W-1];
endmodule

// File: rtl/bitop_bitunit.sv
module bitop_bitunit #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              polarity,
   output logic              bit_val,
   output logic [DATA_W-1:0] data_out
);
   logic [DATA_W-1:0] sel;

   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      assign sel[b]      = (bit_idx == IDX_W'(b));
      assign data_out[b] = sel[b] ? polarity : data_in[b];
   end

   assign bit_val = |(sel & data_in);
endmodule

// File: rtl/bitop_target.sv
module bitop_target #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] base_pc,
   input  logic [DATA_W-1:0] offset,
   input  logic              take,
   output logic [ADDR_W-1:0] next_pc
);
   logic [ADDR_W-1:0] offset_ext;

   assign offset_ext = {{(ADDR_W-DATA_W){offset[DATA_W-1]}}, offset};
   assign next_pc    = take ? (base_pc + offset_ext) : base_pc;
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
   import bitop_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_pc,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              illegal,
   output logic [ADDR_W-1:0] next_pc
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int PAGE_W = ADDR_W - DATA_W;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("bitop_seq: DATA_W must be 8");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_addr_w
      $error("bitop_seq: ADDR_W must exceed DATA_W");
   end

   seq_state_t        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] op_q;
   logic [DATA_W-1:0] zp_q;
   logic [DATA_W-1:0] byte_q;
   logic [ADDR_W-1:0] npc_q;
   logic              bad_q;

   op_group_t         live_group;
   logic [IDX_W-1:0]  live_idx;
   logic              live_pol;
   op_group_t         grp;
   logic [IDX_W-1:0]  idx;
   logic              pol;
   logic              bit_val;
   logic [DATA_W-1:0] byte_mod;
   logic [ADDR_W-1:0] branch_pc;

   logic [ADDR_W-1:0] pc_p1, pc_p2, pc_p3;
   assign pc_p1 = pc_q + ADDR_W'(1);
   assign pc_p2 = pc_q + ADDR_W'(2);
   assign pc_p3 = pc_q + ADDR_W'(3);

   bitop_decode #(.DATA_W(DATA_W)) u_dec_live (
      .opcode   (mem_rdata),
      .group    (live_group),
      .bit_idx  (live_idx),
      .polarity (live_pol)
   );

   bitop_decode #(.DATA_W(DATA_W)) u_dec_held (
      .opcode   (op_q),
      .group    (grp),
      .bit_idx  (idx),
      .polarity (pol)
   );

   bitop_bitunit #(.DATA_W(DATA_W)) u_bit (
      .data_in  (byte_q),
      .bit_idx  (idx),
      .polarity (pol),
      .bit_val  (bit_val),
      .data_out (byte_mod)
   );

   bitop_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
      .base_pc (pc_p3),
      .offset  (mem_rdata),
      .take    (bit_val == pol),
      .next_pc (branch_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         op_q    <= '0;
         zp_q    <= '0;
         byte_q  <= '0;
         npc_q   <= '0;
         bad_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  pc_q    <= start_pc;
                  bad_q   <= 1'b0;
                  state_q <= ST_T1;
               end
            end
            ST_T1: state_q <= ST_T2;
            ST_T2: begin
               op_q <= mem_rdata;
               if (live_group == GRP_NONE) begin
                  npc_q   <= pc_p1;
                  bad_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_T3;
               end
            end
            ST_T3: begin
               zp_q    <= mem_rdata;
               state_q <= ST_T4;
            end
            ST_T4: begin
               byte_q  <= mem_rdata;
               state_q <= ST_T5;
            end
            ST_T5: begin
               npc_q   <= (grp == GRP_BRANCH) ? branch_pc : pc_p2;
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = pc_q;
      mem_wdata = '0;
      unique case (state_q)
         ST_T1: mem_req = 1'b1;
         ST_T2: begin
            mem_req  = 1'b1;
            mem_addr = pc_p1;
         end
         ST_T3: begin
            mem_req  = 1'b1;
            mem_addr = {{PAGE_W{1'b0}}, mem_rdata};
         end
         ST_T4: begin
            mem_req  = 1'b1;
            mem_addr = (grp == GRP_BRANCH) ? pc_p2 : {{PAGE_W{1'b0}}, zp_q};
         end
         ST_T5: begin
            if (grp == GRP_MODIFY) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = {{PAGE_W{1'b0}}, zp_q};
               mem_wdata = byte_mod;
            end
         end
         default: ;
      endcase
   end

   assign done    = (state_q == ST_DONE);
   assign illegal = done & bad_q;
   assign next_pc = npc_q;

   logic unused_ok;
   assign unused_ok = ^{live_idx, live_pol};
endmodule

// File: rtl/bitop_seq_chk.sv
module bitop_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              illegal
);
   // R7: completion strobe lasts one cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: no bus activity in the completion cycle
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);

   // R9: writes stay in page zero
   assert_we_zero_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

   // R3: write follows a dummy read of the same address
   assert_write_after_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(mem_req) && !$past(mem_we) && ($past(mem_addr) == mem_addr)));

   // R3: the write is the last cycle before a legal completion
   assert_write_then_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (done && !illegal));

   // R8: illegal completion is never preceded by a write
   assert_illegal_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !$past(mem_we));

   // R1: a write always comes with a request
   assert_we_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);
endmodule

bind bitop_seq bitop_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .done     (done),
   .illegal  (illegal)
);

// File: tb/bitop_seq_tb.sv
module bitop_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_pc = '0;
   logic        mem_req, mem_we, done, illegal;
   logic [15:0] mem_addr, next_pc;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] mem [logic [15:0]];

   always #10 clk = ~clk;

   bitop_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .illegal(illegal), .next_pc(next_pc)
   );

   function automatic logic [7:0] rd(input logic [15:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   always @(posedge clk) begin
      mem_rdata <= rd(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // one instruction: reference trace built here, compared every cycle
   task automatic run(input int pc, input int op, input int zp, input int zval,
                      input int off, input bit poke);
      int q_req[$], q_we[$], q_addr[$], q_wd[$];
      int idx, pol, nxt, nv, sx;
      string tag;
      pc &= 16'hFFFF;
      mem[16'(pc)] = 8'(op);
      mem[16'(pc + 1)] = 8'(zp);
      mem[16'(pc + 2)] = 8'(off);
      mem[16'(zp)] = 8'(zval);
      idx = (op >> 4) & 7;
      pol = (op >> 7) & 1;
      q_req = {1, 1}; q_we = {0, 0};
      q_addr = {pc, (pc + 1) & 16'hFFFF}; q_wd = {0, 0};
      nv = zval;
      if ((op & 15) == 7) begin
         tag = "R3";
         nv = pol ? (zval | (1 << idx)) : (zval & ~(1 << idx) & 255);
         q_req = {q_req, 1, 1, 1}; q_we = {q_we, 0, 0, 1};
         q_addr = {q_addr, zp, zp, zp}; q_wd = {q_wd, 0, 0, nv};
         nxt = (pc + 2) & 16'hFFFF;
      end else if ((op & 15) == 15) begin
         tag = "R4";
         sx = (off >= 128) ? off - 256 : off;
         q_req = {q_req, 1, 1, 0}; q_we = {q_we, 0, 0, 0};
         q_addr = {q_addr, zp, (pc + 2) & 16'hFFFF, 0}; q_wd = {q_wd, 0, 0, 0};
         nxt = (((zval >> idx) & 1) == pol) ? (pc + 3 + sx) & 16'hFFFF
                                             : (pc + 3) & 16'hFFFF;
      end else begin
         tag = "R8";
         nxt = (pc + 1) & 16'hFFFF;
      end
      start_pc = 16'(pc);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      foreach (q_req[k]) begin
         if (poke && k == 1) begin
            start = 1'b1;
            start_pc = 16'(pc ^ 16'h0404);
         end else begin
            start = 1'b0;
         end
         chk(tag, "mem_req", mem_req, q_req[k]);
         chk(tag, "mem_we", mem_we, q_we[k]);
         if (q_req[k] != 0) chk(tag, "mem_addr", mem_addr, q_addr[k]);
         if (q_we[k] != 0) chk("R10", "mem_wdata", mem_wdata, q_wd[k]);
         chk("R7", "done early", done, 0);
         @(negedge clk);
      end
      start = 1'b0;
      chk("R7", "done", done, 1);
      chk("R8", "illegal", illegal, (tag == "R8") ? 1 : 0);
      chk((tag == "R3") ? "R6" : (tag == "R4") ? "R5" : "R8", "next_pc", next_pc, nxt);
      chk("R7", "quiet bus at done", mem_req, 0);
      @(negedge clk);
      chk("R7", "done pulse width", done, 0);
      chk("R10", "stored byte", rd(16'(zp)), nv);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", done, 0);
      chk("R1", "req in reset", mem_req, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "done idle", done, 0);
      chk("R1", "we idle", mem_we, 0);
      chk("R1", "illegal idle", illegal, 0);

      // R2 R10: every clear/set opcode on two byte patterns
      for (int i = 0; i < 16; i++) begin
         run(16'h0300 + i * 8, (i << 4) | 7, 8'h10 + i, 8'hA5, 0, 0);
         run(16'h0300 + i * 8, (i << 4) | 7, 8'h10 + i, 8'h5A, 0, 0);
      end

      // R2 R5: every branch opcode with its bit set and clear
      for (int i = 0; i < 16; i++) begin
         int b = 1 << (i & 7);
         int offs [4] = '{8'h7F, 8'h80, 8'hFF, 8'h10};
         run(16'h0800 + i * 16, (i << 4) | 15, 8'h40 + i, b, offs[i & 3], 0);
         run(16'h0800 + i * 16, (i << 4) | 15, 8'h40 + i, 255 ^ b, offs[(i + 1) & 3], 0);
      end

      // R5: page crossings forward and backward, and address wrap
      run(16'h12F0, 8'h8F, 8'h60, 8'h01, 8'h20, 0);
      run(16'h1400, 8'h8F, 8'h61, 8'h01, 8'h80, 0);
      run(16'h1500, 8'h7F, 8'h62, 8'h7F, 8'hFF, 0);
      run(16'hFFFC, 8'h0F, 8'h63, 8'hFE, 8'h10, 0);

      // R7: start pulses during a sequence are ignored
      run(16'h2000, 8'hB7, 8'h70, 8'h00, 0, 1);
      run(16'h2100, 8'h3F, 8'h71, 8'h00, 8'h05, 1);

      // R8: opcodes outside both groups
      begin
         int bad_ops [6] = '{8'h00, 8'hEA, 8'h03, 8'h0B, 8'hFE, 8'h80};
         foreach (bad_ops[k]) run(16'h3000 + k * 4, bad_ops[k], 8'h78, 8'h33, 0, k == 2);
      end

      summary();
   end
endmodule